// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Break Detection

This block receives asynchronous serial frames on a single input line. A sample-tick strobe comes from an external rate generator, and the block counts a programmable number of ticks per bit. It first confirms a start bit at its midpoint. It then samples each data bit at its centre, least significant bit first, and checks the stop bit. Frames carry either 8 or 9 data bits. When a frame completes, its data moves into a holding register and a buffer-full flag goes high. In 9-bit mode the extra bit is held in a separate output next to the byte.

A stop bit sampled low is a framing error. After such a frame the receiver watches the line, and if it stays low for ten further bit times the block raises a break flag. A status-read strobe clears the break flag at once when the line is already high. If the line is still low at that moment, the flag stays set and drops by itself as soon as the line returns high. A data-read strobe empties the buffer. The line input is expected to be synchronous to `clk` already, and the configuration must stay stable while a frame is in flight.

Top module: `uart_rx_break`

## Requirements
- R1: After reset, `bufFull`, `frameErr` and `breakDet` are 0.
- R2: `ovsCode` values 0 through 6 select 16 sample ticks per bit; values 7 through 15 select that same number of ticks per bit.
- R3: In 8-bit mode (`nineBit`=0), a frame is one low start bit, 8 data bits sent LSB first, and a stop bit. At the end of the frame `rxData` holds the byte and `bufFull` is 1.
- R4: In 9-bit mode (`nineBit`=1), the first 8 data bits received go to `rxData[7:0]`, LSB first, and the ninth received bit goes to `rxBit9`.
- R5: A one-cycle `bufRead` pulse clears `bufFull`.
- R6: A low pulse on the idle line that returns high before the midpoint of the start bit is discarded: no data is buffered and `bufFull` stays 0.
- R7: A stop bit sampled low sets `frameErr`, and the frame's data is still buffered with `bufFull` set. A `statRead` pulse clears `frameErr`. Frames with a good stop bit do not set it.
- R8: After a missing stop bit, `breakDet` sets on the 10×N-th consecutive low sample tick that follows the stop-bit sample, where N is the ticks per bit. It is 0 one tick earlier.
- R9: While `breakDet` is 1 and the line is high, a `statRead` pulse clears `breakDet`. While the line is high and no `statRead` has arrived, `breakDet` stays 1.
- R10: A `statRead` pulse while the line is still low leaves `breakDet` at 1. `breakDet` then clears once the line returns high.
- R11: If the line goes high after a missing stop bit and before the break threshold, `breakDet` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | One-cycle sample strobe from the rate generator |
| rxd | input | 1 | Serial line, idle high, synchronous to clk |
| ovsCode | input | 4 | Oversampling code (ticks per bit) |
| nineBit | input | 1 | 1 selects 9 data bits per frame |
| bufRead | input | 1 | Pulse that empties the receive buffer |
| statRead | input | 1 | Pulse that clears the error flag and conditionally the break flag |
| rxData | output | 8 | Received byte |
| rxBit9 | output | 1 | Ninth data bit in 9-bit mode |
| bufFull | output | 1 | Receive buffer holds an unread frame |
| frameErr | output | 1 | A stop bit was sampled low |
| breakDet | output | 1 | Line break seen after a framing error |

## Verification
Every one of the 16 oversampling codes is tried in both frame widths. Each run uses a data pattern derived from the code and a different tick gap, so a wrong ticks-per-bit mapping or a wrong bit order corrupts the received value. Framing is tested with bad stop bits that are followed by low stretches of three lengths: just under the break threshold, exactly at it, and released early. The break-clear paths are told apart by issuing the status read once with the line low and once with it high. A short start glitch checks that the midpoint qualification rejects noise.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int OVS_W  = 4;
  localparam int SMP_W  = 5;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic shiftIn;
    logic loadBuf;
    logic setFrameErr;
    logic setBreak;
  } rxStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_BRKHUNT, ST_BRKHOLD
  } rxState_t;

  function automatic logic [SMP_W-1:0] ovsTicks(input logic [OVS_W-1:0] code);
    if (code < OVS_W'(7)) return SMP_W'(16);
    else return SMP_W'(code);
  endfunction
endpackage

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
  import rxb_pkg::*;
#(
  parameter int BRK_BITS = 10,
  localparam int BRK_W = $clog2(BRK_BITS * 16 + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             rxd,
  input  logic [OVS_W-1:0] ovsCode,
  input  logic             nineBit,
  output rxStrobes_t       strb
);
  rxState_t          state, nState;
  logic [SMP_W-1:0]  smpCnt, nSmp;
  logic [3:0]        bitCnt, nBit;
  logic [BRK_W-1:0]  brkCnt, nBrk;
  logic [SMP_W-1:0]  ovsN, halfN;
  logic [BRK_W-1:0]  brkThr;
  logic [3:0]        lastBit;

  assign ovsN    = ovsTicks(ovsCode);
  assign halfN   = ovsN >> 1;
  assign brkThr  = BRK_W'(BRK_BITS * int'(ovsN));
  assign lastBit = nineBit ? 4'(DATA_W) : 4'(DATA_W - 1);

  always_comb begin
    strb   = '0;
    nState = state;
    nSmp   = smpCnt;
    nBit   = bitCnt;
    nBrk   = brkCnt;
    if (sampleTick) begin
      unique case (state)
        ST_IDLE: if (!rxd) begin
          nState = ST_START;
          nSmp   = '0;
        end
        ST_START: begin
          if (rxd) nState = ST_IDLE;
          else if (smpCnt == halfN - SMP_W'(1)) begin
            nState = ST_DATA;
            nSmp   = '0;
            nBit   = '0;
          end else nSmp = smpCnt + SMP_W'(1);
        end
        ST_DATA: begin
          if (smpCnt == ovsN - SMP_W'(1)) begin
            strb.shiftIn = 1'b1;
            nSmp = '0;
            if (bitCnt == lastBit) nState = ST_STOP;
            else nBit = bitCnt + 4'd1;
          end else nSmp = smpCnt + SMP_W'(1);
        end
        ST_STOP: begin
          if (smpCnt == ovsN - SMP_W'(1)) begin
            strb.loadBuf = 1'b1;
            nSmp = '0;
            if (!rxd) begin
              strb.setFrameErr = 1'b1;
              nState = ST_BRKHUNT;
              nBrk   = '0;
            end else nState = ST_IDLE;
          end else nSmp = smpCnt + SMP_W'(1);
        end
        ST_BRKHUNT: begin
          if (rxd) nState = ST_IDLE;
          else if (brkCnt == brkThr - BRK_W'(1)) begin
            strb.setBreak = 1'b1;
            nState = ST_BRKHOLD;
          end else nBrk = brkCnt + BRK_W'(1);
        end
        ST_BRKHOLD: if (rxd) nState = ST_IDLE;
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      smpCnt <= '0;
      bitCnt <= '0;
      brkCnt <= '0;
    end else begin
      state  <= nState;
      smpCnt <= nSmp;
      bitCnt <= nBit;
      brkCnt <= nBrk;
    end
  end

  // R2
  smp_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START || state == ST_DATA || state == ST_STOP) |-> smpCnt < ovsN);

  // R8
  brk_line_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBreak |-> (!rxd && state == ST_BRKHUNT));

  // R7
  ferr_with_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFrameErr |-> strb.loadBuf);
endmodule

// File: rtl/rxb_datapath.sv
module rxb_datapath
  import rxb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxd,
  input  logic              nineBit,
  input  logic              bufRead,
  input  logic              statRead,
  input  rxStrobes_t        strb,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              bufFull,
  output logic              frameErr,
  output logic              breakDet
);
  logic [DATA_W:0] shiftReg;
  logic            clrPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      rxData     <= '0;
      rxBit9     <= 1'b0;
      bufFull    <= 1'b0;
      frameErr   <= 1'b0;
      breakDet   <= 1'b0;
      clrPending <= 1'b0;
    end else begin
      if (strb.shiftIn) shiftReg <= {rxd, shiftReg[DATA_W:1]};

      if (strb.loadBuf) begin
        if (nineBit) begin
          rxData <= shiftReg[DATA_W-1:0];
          rxBit9 <= shiftReg[DATA_W];
        end else begin
          rxData <= shiftReg[DATA_W:1];
          rxBit9 <= 1'b0;
        end
        bufFull <= 1'b1;
      end else if (bufRead) bufFull <= 1'b0;

      if (strb.setFrameErr) frameErr <= 1'b1;
      else if (statRead) frameErr <= 1'b0;

      if (strb.setBreak) begin
        breakDet   <= 1'b1;
        clrPending <= 1'b0;
      end else if (breakDet) begin
        if (rxd && (statRead || clrPending)) begin
          breakDet   <= 1'b0;
          clrPending <= 1'b0;
        end else if (statRead) clrPending <= 1'b1;
      end
    end
  end

  // R3
  full_from_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> $past(strb.loadBuf));

  // R5
  read_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufRead && !strb.loadBuf) |=> !bufFull);

  // R9
  brk_clear_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakDet) |-> $past(rxd));

  // R10
  brk_hold_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (breakDet && !rxd) |=> breakDet);

  // R7
  ferr_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> $past(!rxd));
endmodule

// File: rtl/uart_rx_break.sv
module uart_rx_break
  import rxb_pkg::*;
#(
  parameter int BRK_BITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             rxd,
  input  logic [3:0]       ovsCode,
  input  logic             nineBit,
  input  logic             bufRead,
  input  logic             statRead,
  output logic [7:0]       rxData,
  output logic             rxBit9,
  output logic             bufFull,
  output logic             frameErr,
  output logic             breakDet
);
  rxStrobes_t strb;

  rxb_ctrl #(.BRK_BITS(BRK_BITS)) ctrlInst (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxd(rxd),
    .ovsCode(ovsCode), .nineBit(nineBit), .strb(strb)
  );

  rxb_datapath dpInst (
    .clk(clk), .rstN(rstN), .rxd(rxd), .nineBit(nineBit),
    .bufRead(bufRead), .statRead(statRead), .strb(strb),
    .rxData(rxData), .rxBit9(rxBit9), .bufFull(bufFull),
    .frameErr(frameErr), .breakDet(breakDet)
  );
endmodule

// File: tb/uart_rx_break_test.sv
module uart_rx_break_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic rxd = 1'b1;
  logic [3:0] ovsCode = 4'd0;
  logic nineBit = 1'b0;
  logic bufRead = 1'b0;
  logic statRead = 1'b0;
  logic [7:0] rxData;
  logic rxBit9, bufFull, frameErr, breakDet;

  int checks = 0;
  int errors = 0;
  int gap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_break uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxd(rxd),
    .ovsCode(ovsCode), .nineBit(nineBit), .bufRead(bufRead),
    .statRead(statRead), .rxData(rxData), .rxBit9(rxBit9),
    .bufFull(bufFull), .frameErr(frameErr), .breakDet(breakDet)
  );

  function automatic int ticksOf(input int code);
    return (code < 7) ? 16 : code;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic hold(input logic lv, input int n);
    rxd = lv;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sendFrame(input logic [8:0] d, input logic goodStop);
    int n = ticksOf(int'(ovsCode));
    hold(1'b0, n);
    for (int i = 0; i < (nineBit ? 9 : 8); i++) hold(d[i], n);
    hold(goodStop, n);
  endtask

  task automatic pulseBufRead();
    bufRead = 1'b1; @(negedge clk); bufRead = 1'b0; @(negedge clk);
  endtask

  task automatic pulseStatRead();
    statRead = 1'b1; @(negedge clk); statRead = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 bufFull", int'(bufFull), 0);
    check("R1 frameErr", int'(frameErr), 0);
    check("R1 breakDet", int'(breakDet), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: sweep every code in both widths
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 16; c++) begin
        logic [8:0] d;
        d = 9'((c * 73 + m * 151 + 37) % 512);
        ovsCode = 4'(c);
        nineBit = 1'(m);
        gap = c % 3;
        sendFrame(d, 1'b1);
        hold(1'b1, 2);
        if (m == 0) check("R2 R3 rxData 8-bit", int'(rxData), int'(d[7:0]));
        else begin
          check("R2 R4 rxData 9-bit", int'(rxData), int'(d[7:0]));
          check("R4 rxBit9", int'(rxBit9), int'(d[8]));
        end
        check("R3 bufFull", int'(bufFull), 1);
        check("R7 no frameErr on good stop", int'(frameErr), 0);
        pulseBufRead();
        check("R5 bufFull cleared", int'(bufFull), 0);
      end
    end

    ovsCode = 4'd0;
    nineBit = 1'b0;
    gap = 1;

    // R6 start glitch shorter than half a bit
    hold(1'b0, 3);
    hold(1'b1, 40);
    check("R6 glitch ignored", int'(bufFull), 0);

    // R7 missing stop, then R11 line released before threshold
    sendFrame(9'h0A5, 1'b0);
    check("R7 frameErr set", int'(frameErr), 1);
    check("R7 data still buffered", int'(rxData), 8'hA5);
    check("R7 bufFull", int'(bufFull), 1);
    hold(1'b0, 16 * 5);
    hold(1'b1, 20);
    check("R11 no break on early release", int'(breakDet), 0);
    pulseStatRead();
    check("R7 frameErr cleared", int'(frameErr), 0);
    pulseBufRead();

    // R8 threshold; R10 read while low
    ovsCode = 4'd9;
    sendFrame(9'h000, 1'b0);
    hold(1'b0, 9 * 9 + 4);
    check("R8 no break one tick early", int'(breakDet), 0);
    hold(1'b0, 1);
    check("R8 break at threshold", int'(breakDet), 1);
    hold(1'b0, 5);
    pulseStatRead();
    check("R10 read while low keeps break", int'(breakDet), 1);
    hold(1'b0, 3);
    check("R10 still set while low", int'(breakDet), 1);
    hold(1'b1, 1);
    check("R10 clears on line high", int'(breakDet), 0);
    pulseStatRead();
    pulseBufRead();

    // R9 line high without read keeps flag, read clears it
    ovsCode = 4'd3;
    sendFrame(9'h0FF, 1'b0);
    hold(1'b0, 16 * 11);
    check("R8 break at code 3", int'(breakDet), 1);
    hold(1'b1, 10);
    check("R9 held without read", int'(breakDet), 1);
    pulseStatRead();
    check("R9 read with line high clears", int'(breakDet), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule